// File: doc/BRIEF.md
# TDM Audio Frame Serializer

This block is a master-mode serial audio transmitter. It takes parallel PCM samples through a ready/valid handshake and shifts them out MSB first on a single data line. It produces its own bit clock, frame sync and a per-slot activity flag. Every bit lasts two cycles of the system clock, so the bit clock toggles on each system clock cycle.

The frame is made of 1 to 16 slots. Slot width, sample width, sync shape and sync placement all come from static configuration inputs. The same engine therefore produces two-channel I2S, left-justified, right-justified and DSP-style short-sync framings, as well as wider TDM frames with sparse slot masks. The configuration is held steady while `en` is high and is changed only while `en` is low. Raising `en` starts the first frame at slot 0, bit 0.

Top module: `tdm_frame_tx`

## Requirements
- R1: After reset, and whenever `en` is low, `sd_o` and `slot_act_o` are 0, `s_ready` is 0, `fs_o` sits at its inactive level and `sclk_o` equals `cfg_strobe ^ cfg_invert`.
- R2: While running, each bit occupies two clock cycles. In the first cycle of a bit `sclk_o` equals `cfg_strobe ^ cfg_invert`, and in the second cycle it is inverted. The data line changes only at the start of a bit.
- R3: The number of slots is `cfg_slots_m1 + 1`. Slot width codes are: 1 = 16 bits, 2 = 32 bits, 0 or 3 = equal to the sample width. Sample width codes are: 2 = 8, 3 = 10, 4 = 16, 5 = 20, 6 = 24, 7 = 32 bits. The frame has slot width × slot count bits.
- R4: A sample width code of 0 or 1, or a sample width larger than the slot width, raises `cfg_err_o`. While `cfg_err_o` is high, the block stays idle and never asserts `s_ready`.
- R5: Frame sync is active for `cfg_fs_len_m1 + 1` bits starting at bit 0 of slot 0. With `cfg_fs_early` set, the whole window moves one bit earlier, so sync also covers the last bit of the previous frame.
- R6: `fs_o` is the active indication XOR `cfg_fs_pol` XOR `cfg_invert`. This applies to the inactive idle level as well.
- R7: Sample bits leave MSB first. The sample is taken right-aligned from `s_data`. It begins at bit 0 of the slot, or at bit (slot width − sample width) when `cfg_rjust` is set. All other bits are 0.
- R8: Bit i of `cfg_slot_mask` enables slot i. Mask bits above the slot count are ignored. If no slot within the frame is enabled, all of them are. Disabled slots drive 0 and keep `slot_act_o` low, and `slot_act_o` is high for every bit of an enabled slot.
- R9: `s_ready` is high for one cycle, the cycle just before the first bit of a slot that takes a sample. The sample is taken in that cycle. If `s_valid` is low at that moment, zeros are sent instead.
- R10: With `cfg_mono` set and exactly two slots, one sample is taken at slot 0 and sent in both slots. With any other slot count, `cfg_mono` has no effect.
- R11: Dropping `en` returns the outputs to idle on the next clock. A later start begins again at slot 0, bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable |
| cfg_slots_m1 | input | 4 | Slot count minus one |
| cfg_slot_size | input | 2 | Slot width code |
| cfg_data_size | input | 3 | Sample width code |
| cfg_fs_len_m1 | input | 9 | Frame sync active length minus one, in bits |
| cfg_fs_early | input | 1 | Sync starts one bit before slot 0 |
| cfg_fs_pol | input | 1 | Frame sync polarity invert |
| cfg_rjust | input | 1 | Right-justify the sample inside its slot |
| cfg_slot_mask | input | 16 | Per-slot enable mask |
| cfg_mono | input | 1 | Send one sample in both slots of a two-slot frame |
| cfg_strobe | input | 1 | Selects the bit clock edge that launches data |
| cfg_invert | input | 1 | Inverts both the bit clock and the frame sync |
| s_valid | input | 1 | Sample valid |
| s_data | input | 32 | Sample, right-aligned |
| s_ready | output | 1 | Sample taken this cycle |
| sclk_o | output | 1 | Bit clock |
| fs_o | output | 1 | Frame sync |
| sd_o | output | 1 | Serial data |
| slot_act_o | output | 1 | Current slot is enabled |
| cfg_err_o | output | 1 | Configuration is inconsistent |

## Verification
The assertions assume that every configuration input stays steady while `en` is high. Under that assumption, a running engine never changes its clock phase or data outside a bit boundary. The stimulus honours this by changing the configuration only after `en` has been low for at least one clock. Samples and `s_valid` are changed only on the falling clock edge that follows a taken sample, so a sample is never altered while it is being offered.

// File: rtl/tdm_frame_tx.sv
module tdm_frame_tx #(
  parameter int MAX_SLOTS = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   en,
  input  logic [$clog2(MAX_SLOTS)-1:0]           cfg_slots_m1,
  input  logic [1:0]                             cfg_slot_size,
  input  logic [2:0]                             cfg_data_size,
  input  logic [$clog2(MAX_SLOTS*32)-1:0]        cfg_fs_len_m1,
  input  logic                                   cfg_fs_early,
  input  logic                                   cfg_fs_pol,
  input  logic                                   cfg_rjust,
  input  logic [MAX_SLOTS-1:0]                   cfg_slot_mask,
  input  logic                                   cfg_mono,
  input  logic                                   cfg_strobe,
  input  logic                                   cfg_invert,
  input  logic                                   s_valid,
  input  logic [31:0]                            s_data,
  output logic                                   s_ready,
  output logic                                   sclk_o,
  output logic                                   fs_o,
  output logic                                   sd_o,
  output logic                                   slot_act_o,
  output logic                                   cfg_err_o
);
  localparam int SW = $clog2(MAX_SLOTS);
  localparam int FW = $clog2(MAX_SLOTS*32);

  logic [5:0] ds, sw, off, rel;
  logic [4:0] idx;
  logic [SW:0] nslots;
  logic [FW:0] flen, fs_len, fp;
  logic [MAX_SLOTS-1:0] nmask, men;
  logic mono, run, bnd, pop, nact, nsd, nfs, infield;

  logic started, ph, sd_q, act_q, fs_q;
  logic [FW-1:0] fb, nfb;
  logic [SW-1:0] sl, nsl;
  logic [4:0] bi, nbi;
  logic [31:0] hold, smp;

  always_comb begin
    case (cfg_data_size)
      3'd2: ds = 6'd8;
      3'd3: ds = 6'd10;
      3'd4: ds = 6'd16;
      3'd5: ds = 6'd20;
      3'd6: ds = 6'd24;
      3'd7: ds = 6'd32;
      default: ds = 6'd0;
    endcase
    case (cfg_slot_size)
      2'd1: sw = 6'd16;
      2'd2: sw = 6'd32;
      default: sw = ds;
    endcase
  end

  assign cfg_err_o = (ds == 6'd0) || (ds > sw);
  assign nslots = {1'b0, cfg_slots_m1} + (SW+1)'(1);
  assign flen   = (FW+1)'(nslots) * (FW+1)'(sw);
  assign fs_len = {1'b0, cfg_fs_len_m1} + (FW+1)'(1);
  assign off    = cfg_rjust ? (sw - ds) : 6'd0;
  assign mono   = cfg_mono && (nslots == (SW+1)'(2));

  always_comb begin
    for (int i = 0; i < MAX_SLOTS; i++) nmask[i] = (i < int'(nslots));
    men = ((cfg_slot_mask & nmask) == '0) ? nmask : (cfg_slot_mask & nmask);
  end

  assign run = en && !cfg_err_o;
  assign bnd = run && (!started || ph);

  always_comb begin
    nfb = '0;
    nsl = '0;
    nbi = '0;
    if (started) begin
      if ({1'b0, bi} == sw - 6'd1) begin
        if (sl != cfg_slots_m1) begin
          nsl = sl + SW'(1);
          nfb = fb + FW'(1);
        end
      end else begin
        nbi = bi + 5'd1;
        nsl = sl;
        nfb = fb + FW'(1);
      end
    end
  end

  assign nact    = men[nsl];
  assign pop     = bnd && (nbi == 5'd0) && (mono ? (nsl == '0) : nact);
  assign s_ready = pop;
  assign smp     = pop ? (s_valid ? s_data : 32'd0) : hold;
  assign rel     = {1'b0, nbi} - off;
  assign infield = ({1'b0, nbi} >= off) && (rel < ds);
  assign idx     = 5'(ds - 6'd1 - rel);
  assign nsd     = nact && infield && smp[idx];
  assign fp      = {1'b0, nfb} + (FW+1)'(1);
  assign nfs     = cfg_fs_early ? ((fp == flen) || (fp < fs_len))
                                : ({1'b0, nfb} < fs_len);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      started <= 1'b0;
      ph      <= 1'b0;
      fb      <= '0;
      sl      <= '0;
      bi      <= '0;
      sd_q    <= 1'b0;
      act_q   <= 1'b0;
      fs_q    <= 1'b0;
      if (!rst_n) hold <= '0;
    end else begin
      started <= 1'b1;
      ph      <= !bnd;
      if (bnd) begin
        fb    <= nfb;
        sl    <= nsl;
        bi    <= nbi;
        sd_q  <= nsd;
        act_q <= nact;
        fs_q  <= nfs;
      end
      if (pop) hold <= smp;
    end
  end

  assign sclk_o     = ph ^ cfg_strobe ^ cfg_invert;
  assign fs_o       = fs_q ^ cfg_fs_pol ^ cfg_invert;
  assign sd_o       = sd_q;
  assign slot_act_o = act_q;
endmodule

// File: rtl/tdm_frame_tx_chk.sv
module tdm_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic started,
  input logic ph,
  input logic s_ready,
  input logic sclk_o,
  input logic sd_o,
  input logic slot_act_o,
  input logic cfg_err_o
);
  // R2
  sclk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(started)) |-> (sclk_o != $past(sclk_o)));

  // R2
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !ph && en) |=> ($stable(sd_o) && $stable(slot_act_o)));

  // R9
  pop_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (ph || !started));

  // R8
  data_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_o |-> slot_act_o);

  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sd_o && !slot_act_o));

  // R4
  err_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> !s_ready);
endmodule

bind tdm_frame_tx tdm_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .started(started), .ph(ph),
  .s_ready(s_ready), .sclk_o(sclk_o), .sd_o(sd_o),
  .slot_act_o(slot_act_o), .cfg_err_o(cfg_err_o)
);

// File: tb/sim_tdm_frame_tx.sv
`timescale 1ns/1ps
module sim_tdm_frame_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [3:0] cfg_slots_m1 = '0;
  logic [1:0] cfg_slot_size = '0;
  logic [2:0] cfg_data_size = '0;
  logic [8:0] cfg_fs_len_m1 = '0;
  logic cfg_fs_early = 1'b0, cfg_fs_pol = 1'b0, cfg_rjust = 1'b0;
  logic [15:0] cfg_slot_mask = '0;
  logic cfg_mono = 1'b0, cfg_strobe = 1'b0, cfg_invert = 1'b0;
  logic s_valid = 1'b1;
  logic [31:0] s_data = 32'h0;
  logic s_ready, sclk_o, fs_o, sd_o, slot_act_o, cfg_err_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tdm_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_slots_m1(cfg_slots_m1),
    .cfg_slot_size(cfg_slot_size), .cfg_data_size(cfg_data_size),
    .cfg_fs_len_m1(cfg_fs_len_m1), .cfg_fs_early(cfg_fs_early),
    .cfg_fs_pol(cfg_fs_pol), .cfg_rjust(cfg_rjust),
    .cfg_slot_mask(cfg_slot_mask), .cfg_mono(cfg_mono),
    .cfg_strobe(cfg_strobe), .cfg_invert(cfg_invert),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .sclk_o(sclk_o), .fs_o(fs_o), .sd_o(sd_o),
    .slot_act_o(slot_act_o), .cfg_err_o(cfg_err_o)
  );

  function automatic int ds_of(input int code);
    case (code)
      2: return 8;  3: return 10; 4: return 16;
      5: return 20; 6: return 24; 7: return 32;
      default: return 0;
    endcase
  endfunction

  function automatic int sw_of(input int sz, input int code);
    if (sz == 1) return 16;
    if (sz == 2) return 32;
    return ds_of(code);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic base();
    cfg_slots_m1 = 4'd1; cfg_slot_size = 2'd0; cfg_data_size = 3'd4;
    cfg_fs_len_m1 = 9'd0; cfg_fs_early = 0; cfg_fs_pol = 0; cfg_rjust = 0;
    cfg_slot_mask = 16'h0; cfg_mono = 0; cfg_strobe = 0; cfg_invert = 0;
  endtask

  task automatic check_idle(input string req);
    chk(sd_o == 1'b0, req, sd_o, 0);
    chk(slot_act_o == 1'b0, req, slot_act_o, 0);
    chk(s_ready == 1'b0, req, s_ready, 0);
    chk(fs_o == (cfg_fs_pol ^ cfg_invert), "R6", fs_o, cfg_fs_pol ^ cfg_invert);
    chk(sclk_o == (cfg_strobe ^ cfg_invert), req, sclk_o, cfg_strobe ^ cfg_invert);
  endtask

  task automatic halt();
    @(negedge clk); en = 1'b0;
    @(posedge clk); @(negedge clk);
    check_idle("R11");
  endtask

  task automatic go(input int nbits, input string tag);
    int n, sw, ds, L, A, off, m, fb, sl, bi;
    bit mono, act, pop, took, inf, sdx, fsa, se;
    logic [31:0] hold_m;
    n = int'(cfg_slots_m1) + 1;
    ds = ds_of(int'(cfg_data_size));
    sw = sw_of(int'(cfg_slot_size), int'(cfg_data_size));
    L = sw * n;
    A = int'(cfg_fs_len_m1) + 1;
    off = cfg_rjust ? sw - ds : 0;
    m = int'(cfg_slot_mask) & ((1 << n) - 1);
    if (m == 0) m = (1 << n) - 1;
    mono = cfg_mono && (n == 2);
    se = cfg_strobe ^ cfg_invert;
    hold_m = '0;
    @(negedge clk);
    check_idle("R1");
    en = 1'b1;
    for (int k = 0; k < nbits; k++) begin
      fb = k % L; sl = fb / sw; bi = fb % sw;
      act = m[sl];
      pop = (bi == 0) && (mono ? (sl == 0) : act);
      #1;
      chk(s_ready == pop, "R9", s_ready, pop);
      if (pop) hold_m = s_valid ? s_data : 32'd0;
      took = pop;
      @(posedge clk); @(negedge clk);
      inf = (bi >= off) && (bi - off < ds);
      sdx = act && inf && hold_m[ds - 1 - (bi - off)];
      fsa = cfg_fs_early ? ((fb + 1 == L) || (fb + 1 < A)) : (fb < A);
      chk(sd_o == sdx, tag, sd_o, sdx);
      chk(slot_act_o == act, "R8", slot_act_o, act);
      chk(fs_o == (fsa ^ cfg_fs_pol ^ cfg_invert), "R5", fs_o, fsa ^ cfg_fs_pol ^ cfg_invert);
      chk(sclk_o == se, "R2", sclk_o, se);
      chk(s_ready == 1'b0, "R9", s_ready, 0);
      if (took) begin
        s_data = $urandom;
        s_valid = ($urandom % 4) != 0;
      end
      @(posedge clk); @(negedge clk);
      chk(sclk_o == !se, "R2", sclk_o, !se);
    end
  endtask

  task automatic err_run(input int cyc);
    @(negedge clk); en = 1'b1;
    for (int c = 0; c < cyc; c++) begin
      #1;
      chk(cfg_err_o == 1'b1, "R4", cfg_err_o, 1);
      chk(s_ready == 1'b0, "R4", s_ready, 0);
      @(posedge clk); @(negedge clk);
      chk(sd_o == 1'b0 && slot_act_o == 1'b0, "R4", sd_o | slot_act_o, 0);
    end
    halt();
  endtask

  task automatic full(input string tag);
    int n, sw;
    n = int'(cfg_slots_m1) + 1;
    sw = sw_of(int'(cfg_slot_size), int'(cfg_data_size));
    go(2 * n * sw, tag);
    halt();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    s_data = $urandom;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;

    // R3 two-slot 16-bit with early, inverted sync
    base(); cfg_slot_size = 2'd1; cfg_fs_len_m1 = 9'd15; cfg_fs_early = 1; cfg_fs_pol = 1;
    full("R3");
    // R7 left-justified 24 in 32
    base(); cfg_slot_size = 2'd2; cfg_data_size = 3'd6; cfg_fs_len_m1 = 9'd31;
    full("R7");
    // R7 right-justified 24 in 32
    cfg_rjust = 1; full("R7");
    // R5 short sync one bit early, 10-bit samples in 16-bit slots
    base(); cfg_slots_m1 = 4'd3; cfg_slot_size = 2'd1; cfg_data_size = 3'd3; cfg_fs_early = 1;
    full("R5");
    // R2 short sync on first bit, other launch edge
    cfg_fs_early = 0; cfg_strobe = 1; full("R2");
    // R8 sparse mask, then R11 stop part way and restart
    base(); cfg_slots_m1 = 4'd7; cfg_slot_size = 2'd1; cfg_slot_mask = 16'h00A5; cfg_fs_len_m1 = 9'd3;
    go(77, "R8"); halt();
    full("R11");
    // R8 mask empty inside frame means all slots
    base(); cfg_slots_m1 = 4'd3; cfg_data_size = 3'd2; cfg_slot_mask = 16'hFF00;
    full("R8");
    // R10 mono in two slots
    base(); cfg_slot_size = 2'd2; cfg_data_size = 3'd5; cfg_mono = 1; cfg_fs_len_m1 = 9'd31;
    full("R10");
    // R10 mono flag ignored with four slots
    cfg_slots_m1 = 4'd3; full("R10");
    // R6 invert flips clock and sync
    base(); cfg_invert = 1; cfg_fs_len_m1 = 9'd15; full("R6");
    // R3 sixteen slots of 8 bits
    base(); cfg_slots_m1 = 4'd15; cfg_data_size = 3'd2; cfg_fs_len_m1 = 9'd63;
    full("R3");
    // R4 sample wider than slot, and an invalid sample code
    base(); cfg_slot_size = 2'd1; cfg_data_size = 3'd7; err_run(20);
    base(); cfg_data_size = 3'd1; err_run(10);

    for (int r = 0; r < 12; r++) begin
      int swr, lr;
      base();
      cfg_slots_m1 = 4'($urandom % 16);
      cfg_slot_size = 2'($urandom % 3);
      cfg_data_size = 3'(2 + $urandom % 6);
      if (ds_of(int'(cfg_data_size)) > sw_of(int'(cfg_slot_size), int'(cfg_data_size)))
        cfg_slot_size = 2'd0;
      swr = sw_of(int'(cfg_slot_size), int'(cfg_data_size));
      lr = swr * (int'(cfg_slots_m1) + 1);
      cfg_fs_len_m1 = 9'($urandom % lr);
      cfg_slot_mask = ($urandom % 4 == 0) ? 16'h0 : 16'($urandom);
      cfg_fs_early = 1'($urandom); cfg_fs_pol = 1'($urandom);
      cfg_rjust = 1'($urandom); cfg_mono = 1'($urandom);
      cfg_strobe = 1'($urandom); cfg_invert = 1'($urandom);
      if ($urandom % 3 == 0) cfg_slots_m1 = 4'd1;
      full("R7");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule